// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

The block is a full-duplex, 8-bit, clock-synchronous serial unit. A byte handed in on the transmit stream is shifted out on `txd`. During the same eight bit times a byte is shifted in from `rxd` and is offered on the receive stream. Reception has no separate trigger. A transmit byte starts every transfer, and a dummy byte is used when only receiving.

The transfer clock comes from one of two sources. It can be generated inside the block: a prescaler divides the system clock by 2, 16, 64 or 512, and an 8-bit reload divider then divides that count. It can also be taken from an external clock pin. Further controls select:
- the sampling edge,
- the bit order,
- an optional flow-control pin that acts either as a clear-to-send input or a ready-to-receive output,
- whether the interrupt request marks every completed byte or only overruns.

Stream rules:
- Transmit side: `tx_valid` must hold with stable `tx_data` until `tx_ready` is seen high at a clock edge.
- Receive side: it cannot stall the serial line. A byte that `rx_ready` has not taken before the next byte completes is overwritten, and the overrun flag is raised.

Top module: `sync_serial_xcvr`

## Requirements
- R1: `tx_ready` is high exactly when the transmit buffer is empty, and a byte is taken when `tx_valid` and `tx_ready` are both high at a clock edge. A buffered byte starts a transfer only while `tx_en` and `rx_en` are both 1; until then no transfer clock edge appears and `tx_ready` stays low.
- R2: With `msb_first` = 0 bit 0 is shifted first on both `txd` and `rxd`; with `msb_first` = 1 bit 7 is shifted first.
- R3: With the internal clock, each half-period of `sclk_o` lasts D×(`baud_reload`+1) system clocks, where `src_sel` 00, 01, 10, 11 gives D = 2, 16, 64, 512. The idle level of the transfer clock is 1 when `sample_on_fall` = 0 and 0 when it is 1.
- R4: Receive data is sampled on the transfer clock edge that returns the clock to its idle level (rising when `sample_on_fall` = 0, falling when 1). `txd` changes on the edge that leaves idle. `txd` rests at 1 outside transfers.
- R5: With `clk_ext_sel` = 1 the transfer is clocked by edges of `sclk_i`, and `sclk_o` stays at the idle level throughout.
- R6: When the eighth bit has been received, `rx_valid` rises and `tx_ready` rises in the same cycle. A read (`rx_valid` and `rx_ready` high at an edge) clears `rx_valid`.
- R7: If a byte completes while `rx_valid` is high and is not read in that cycle, `ovr_err` becomes 1 and `rx_data` is replaced by the new byte. A read clears `ovr_err`.
- R8: With `hs_off` = 0 and `hs_rts_mode` = 0, no transfer starts while `cts_i` is high, and `rts_o` stays 1. With `hs_off` = 1, `cts_i` is ignored.
- R9: With `hs_off` = 0 and `hs_rts_mode` = 1, `rts_o` is 0 exactly while `rx_en` is 1, no transfer is in progress and `rx_valid` is 0; otherwise it is 1. With `hs_off` = 1, `rts_o` is 1.
- R10: `irq` is a one-cycle pulse in the cycle `rx_valid` is set by a completion. With `irq_err_only` = 0 it fires on every completion; with 1 it fires only on a completion that sets `ovr_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_ext_sel | input | 1 | 0: internal transfer clock, 1: external `sclk_i` |
| src_sel | input | 2 | Prescaler choice: /2, /16, /64, /512 |
| baud_reload | input | 8 | Divider reload; half-period = reload+1 prescaled ticks |
| sample_on_fall | input | 1 | 0: sample on rising edge, 1: on falling edge |
| msb_first | input | 1 | Bit order select |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| hs_off | input | 1 | 1: flow-control pin disabled |
| hs_rts_mode | input | 1 | 0: clear-to-send input, 1: ready-to-receive output |
| irq_err_only | input | 1 | 0: irq on every byte, 1: irq on overrun only |
| tx_valid | input | 1 | Transmit stream valid |
| tx_ready | output | 1 | Transmit buffer empty |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Receive byte available |
| rx_ready | input | 1 | Receive stream consumer ready |
| rx_data | output | 8 | Received byte |
| ovr_err | output | 1 | Overrun flag |
| irq | output | 1 | Interrupt request pulse |
| sclk_i | input | 1 | External transfer clock |
| sclk_o | output | 1 | Internally generated transfer clock |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |
| cts_i | input | 1 | Clear-to-send input (active low) |
| rts_o | output | 1 | Ready-to-receive output (active low) |

## Verification
The embedded assertions check the rules that hold on every cycle:
- the transmit buffer is never shown empty during a transfer;
- a completion raises `rx_valid` and `tx_ready` on the next edge;
- the interrupt is a single-cycle pulse;
- overrun sets its flag;
- a blocked clear-to-send input keeps an idle unit idle;
- the divider never emits back-to-back half-period ticks.

Only the bench scenarios can show the end-to-end behaviour, using a serial peer model. Those scenarios cover:
- the bytes actually exchanged in both bit orders;
- the exact half-period for each prescaler choice;
- the idle level for each sampling edge;
- that the external clock leaves `sclk_o` still;
- the enable and flow-control gating;
- the ready-to-receive level across a full transfer and read.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  localparam int PRE_W = 9;

  typedef enum logic [1:0] {
    SRC_DIV2   = 2'b00,
    SRC_DIV16  = 2'b01,
    SRC_DIV64  = 2'b10,
    SRC_DIV512 = 2'b11
  } ssx_src_e;

  function automatic logic [PRE_W-1:0] pre_mask(input ssx_src_e s);
    case (s)
      SRC_DIV2:   pre_mask = PRE_W'(1);
      SRC_DIV16:  pre_mask = PRE_W'(15);
      SRC_DIV64:  pre_mask = PRE_W'(63);
      default:    pre_mask = PRE_W'(511);
    endcase
  endfunction
endpackage

// File: rtl/ssx_baud_gen.sv
module ssx_baud_gen
  import ssx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       src_sel,
  input  logic [DIV_W-1:0] reload,
  output logic             half_tick
);
  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [PRE_W-1:0] mask;
  logic             pre_tick;

  assign mask      = pre_mask(ssx_src_e'(src_sel));
  assign pre_tick  = run && ((pre_cnt & mask) == mask);
  assign half_tick = pre_tick && (div_cnt == reload);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (!run) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
      if (pre_tick) div_cnt <= (div_cnt == reload) ? '0 : div_cnt + 1'b1;
    end
  end

  // R3
  half_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |=> !half_tick);
endmodule

// File: rtl/ssx_clk_ctrl.sv
module ssx_clk_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ext_sel,
  input  logic sample_on_fall,
  input  logic half_tick,
  input  logic sclk_i,
  output logic sclk_o,
  output logic launch,
  output logic sample
);
  logic idle_lvl;
  logic sclk_int;
  logic ext_s1, ext_s2, ext_s3;
  logic edge_ev, new_lvl;

  assign idle_lvl = ~sample_on_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_int <= 1'b1;
      ext_s1   <= 1'b1;
      ext_s2   <= 1'b1;
      ext_s3   <= 1'b1;
    end else begin
      ext_s1 <= sclk_i;
      ext_s2 <= ext_s1;
      ext_s3 <= ext_s2;
      if (!run || ext_sel) sclk_int <= idle_lvl;
      else if (half_tick)  sclk_int <= ~sclk_int;
    end
  end

  assign edge_ev = ext_sel ? (ext_s2 ^ ext_s3) : half_tick;
  assign new_lvl = ext_sel ? ext_s2 : ~sclk_int;
  assign launch  = run && edge_ev && (new_lvl != idle_lvl);
  assign sample  = run && edge_ev && (new_lvl == idle_lvl);
  assign sclk_o  = (ext_sel || !run) ? idle_lvl : sclk_int;
endmodule

// File: rtl/ssx_shifter.sv
module ssx_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] tx_byte,
  input  logic         msb_first,
  input  logic         launch,
  input  logic         sample,
  input  logic         rxd,
  output logic         txd,
  output logic [W-1:0] rx_byte,
  output logic         done
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  tx_sh;
  logic [CW-1:0] bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      rx_byte <= '0;
      bit_cnt <= '0;
      txd     <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= sample && (bit_cnt == CW'(W-1));
      if (load) begin
        tx_sh   <= tx_byte;
        bit_cnt <= '0;
        txd     <= 1'b1;
      end else begin
        if (launch) begin
          txd   <= msb_first ? tx_sh[W-1] : tx_sh[0];
          tx_sh <= msb_first ? {tx_sh[W-2:0], 1'b0} : {1'b0, tx_sh[W-1:1]};
        end
        if (sample) begin
          rx_byte <= msb_first ? {rx_byte[W-2:0], rxd} : {rxd, rx_byte[W-1:1]};
          bit_cnt <= bit_cnt + 1'b1;
        end
        if (done) txd <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_ext_sel,
  input  logic [1:0]        src_sel,
  input  logic [DIV_W-1:0]  baud_reload,
  input  logic              sample_on_fall,
  input  logic              msb_first,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              hs_off,
  input  logic              hs_rts_mode,
  input  logic              irq_err_only,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              ovr_err,
  output logic              irq,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              txd,
  input  logic              rxd,
  input  logic              cts_i,
  output logic              rts_o
);
  logic              tx_full, busy, rx_full;
  logic [DATA_W-1:0] tx_buf, rx_buf, rx_byte;
  logic              cts_s1, cts_s2, cts_block;
  logic              start, done, rd, ovr_now;
  logic              half_tick, launch, sample;

  ssx_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(busy && !clk_ext_sel),
    .src_sel(src_sel), .reload(baud_reload), .half_tick(half_tick)
  );

  ssx_clk_ctrl u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .ext_sel(clk_ext_sel),
    .sample_on_fall(sample_on_fall), .half_tick(half_tick), .sclk_i(sclk_i),
    .sclk_o(sclk_o), .launch(launch), .sample(sample)
  );

  ssx_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(start), .tx_byte(tx_buf),
    .msb_first(msb_first), .launch(launch), .sample(sample), .rxd(rxd),
    .txd(txd), .rx_byte(rx_byte), .done(done)
  );

  assign cts_block = !hs_off && !hs_rts_mode && cts_s2;
  assign start     = tx_full && !busy && tx_en && rx_en && !cts_block;
  assign rd        = rx_full && rx_ready;
  assign ovr_now   = rx_full && !rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_s1  <= 1'b1;
      cts_s2  <= 1'b1;
      tx_full <= 1'b0;
      tx_buf  <= '0;
      busy    <= 1'b0;
      rx_full <= 1'b0;
      rx_buf  <= '0;
      ovr_err <= 1'b0;
      irq     <= 1'b0;
    end else begin
      cts_s1 <= cts_i;
      cts_s2 <= cts_s1;
      irq    <= done && (!irq_err_only || ovr_now);
      if (tx_valid && !tx_full) begin
        tx_full <= 1'b1;
        tx_buf  <= tx_data;
      end else if (done) begin
        tx_full <= 1'b0;
      end
      if (start)     busy <= 1'b1;
      else if (done) busy <= 1'b0;
      if (done) begin
        rx_buf  <= rx_byte;
        rx_full <= 1'b1;
        ovr_err <= ovr_now;
      end else if (rd) begin
        rx_full <= 1'b0;
        ovr_err <= 1'b0;
      end
    end
  end

  assign tx_ready = !tx_full;
  assign rx_valid = rx_full;
  assign rx_data  = rx_buf;
  assign rts_o    = (!hs_off && hs_rts_mode) ? !(rx_en && !busy && !rx_full) : 1'b1;

  // R1
  busy_holds_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tx_ready);
  // R6
  done_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (rx_valid && tx_ready));
  // R10
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rx_valid && !rx_ready) |=> ovr_err);
  // R8
  cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_off && !hs_rts_mode && cts_s2 && !busy) |=> !busy);
endmodule

// File: tb/tb_sync_serial_xcvr.sv
module tb_sync_serial_xcvr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_ext = 0, cfg_sof = 0, cfg_msb = 0;
  logic [1:0] cfg_src = 0;
  logic [7:0] cfg_baud = 0;
  logic tx_en = 1, rx_en = 1, hs_off = 1, hs_rts = 0, err_only = 0;
  logic tx_valid = 0, rx_ready = 1, sclk_i = 1, rxd = 1, cts_i = 1;
  logic [7:0] tx_data = 0;
  logic tx_ready, rx_valid, ovr_err, irq, sclk_o, txd, rts_o;
  logic [7:0] rx_data;
  logic sclk_line;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, last_t = 0, half_meas = 0, tog_cnt = 0;
  logic last_s = 1'bx;
  int pidx = 0;
  logic [7:0] peer_out = 0, peer_in = 0;
  logic [7:0] q_data[$];
  logic       q_ovr[$];

  always #10 clk = ~clk;

  sync_serial_xcvr dut (
    .clk(clk), .rst_n(rst_n), .clk_ext_sel(cfg_ext), .src_sel(cfg_src),
    .baud_reload(cfg_baud), .sample_on_fall(cfg_sof), .msb_first(cfg_msb),
    .tx_en(tx_en), .rx_en(rx_en), .hs_off(hs_off), .hs_rts_mode(hs_rts),
    .irq_err_only(err_only), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .ovr_err(ovr_err), .irq(irq), .sclk_i(sclk_i),
    .sclk_o(sclk_o), .txd(txd), .rxd(rxd), .cts_i(cts_i), .rts_o(rts_o)
  );

  assign sclk_line = cfg_ext ? sclk_i : sclk_o;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // serial peer: drives rxd on the edge leaving idle, captures txd on the edge back to idle
  always @(sclk_line) begin
    if (sclk_line === cfg_sof) begin
      if (pidx < 8) rxd = peer_out[cfg_msb ? 7 - pidx : pidx];
    end else if (pidx < 8) begin
      peer_in[cfg_msb ? 7 - pidx : pidx] = txd;
      pidx++;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (sclk_o !== last_s) begin
      half_meas = cyc - last_t;
      last_t = cyc;
      last_s = sclk_o;
      tog_cnt++;
    end
  end

  // scoreboard monitor: compares each byte taken off the receive stream
  always @(posedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      if (q_data.size() == 0) begin
        chk(0, "R6 unexpected read", int'(rx_data), 0);
      end else begin
        logic [7:0] ed;
        logic eo;
        ed = q_data.pop_front();
        eo = q_ovr.pop_front();
        chk(rx_data == ed, "R2 rx byte", int'(rx_data), int'(ed));
        chk(ovr_err == eo, "R7 ovr with byte", int'(ovr_err), int'(eo));
      end
    end
  end

  task automatic begin_xfer(input logic [7:0] t, input logic [7:0] r,
                            input bit push, input bit eovr);
    peer_out = r;
    pidx = 0;
    if (push) begin
      q_data.push_back(r);
      q_ovr.push_back(eovr);
    end
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = t;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(tx_ready == 1'b0, "R1 buffer full after write", int'(tx_ready), 0);
  endtask

  task automatic finish_xfer(input logic [7:0] t, input bit eirq, input string tag);
    int n;
    if (cfg_ext) begin
      for (int i = 0; i < 16; i++) begin
        repeat (8) @(negedge clk);
        sclk_i = ~sclk_i;
      end
    end
    n = 0;
    while (!tx_ready && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(rx_valid == 1'b1, "R6 rx_valid with tx_ready", int'(rx_valid), 1);
    chk(irq == eirq, "R10 irq at completion", int'(irq), int'(eirq));
    chk(peer_in == t, tag, int'(peer_in), int'(t));
    @(negedge clk);
    chk(irq == 1'b0, "R10 irq one cycle", int'(irq), 0);
    chk(txd == 1'b1, "R4 txd idle", int'(txd), 1);
  endtask

  task automatic set_idle();
    sclk_i = ~cfg_sof;
    repeat (4) @(negedge clk);
  endtask

  initial begin : main
    int tg;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_ready == 1, "R1 reset tx_ready", int'(tx_ready), 1);
    chk(rx_valid == 0, "R6 reset rx_valid", int'(rx_valid), 0);
    chk(ovr_err == 0, "R7 reset ovr", int'(ovr_err), 0);
    chk(irq == 0, "R10 reset irq", int'(irq), 0);
    chk(txd == 1, "R4 reset txd", int'(txd), 1);
    chk(sclk_o == 1, "R3 idle high", int'(sclk_o), 1);
    chk(rts_o == 1, "R9 off rts", int'(rts_o), 1);

    // internal clock, /2, reload 0, lsb first; cts_i high is ignored (R8)
    begin_xfer(8'hA5, 8'h3C, 1, 0);
    finish_xfer(8'hA5, 1, "R2 lsb tx");
    chk(half_meas == 2, "R3 half /2 r0", half_meas, 2);

    cfg_msb = 1; cfg_src = 2'b01; cfg_baud = 8'd2;
    begin_xfer(8'h81, 8'h6E, 1, 0);
    finish_xfer(8'h81, 1, "R2 msb tx");
    chk(half_meas == 48, "R3 half /16 r2", half_meas, 48);

    cfg_msb = 0; cfg_sof = 1; cfg_src = 2'b00; cfg_baud = 8'd3;
    set_idle();
    chk(sclk_o == 0, "R3 idle low", int'(sclk_o), 0);
    begin_xfer(8'h5A, 8'hC3, 1, 0);
    finish_xfer(8'h5A, 1, "R4 falling sample tx");
    chk(half_meas == 8, "R3 half /2 r3", half_meas, 8);

    cfg_sof = 0; cfg_src = 2'b10; cfg_baud = 8'd1;
    set_idle();
    begin_xfer(8'h0F, 8'hF0, 1, 0);
    finish_xfer(8'h0F, 1, "R4 rising sample tx");
    chk(half_meas == 128, "R3 half /64 r1", half_meas, 128);

    cfg_src = 2'b11; cfg_baud = 8'd0; cfg_msb = 1;
    begin_xfer(8'hC6, 8'h19, 1, 0);
    finish_xfer(8'hC6, 1, "R2 msb /512 tx");
    chk(half_meas == 512, "R3 half /512 r0", half_meas, 512);

    // external clock, both sampling edges
    cfg_ext = 1; cfg_msb = 0; cfg_sof = 1;
    set_idle();
    tg = tog_cnt;
    begin_xfer(8'h96, 8'h2D, 1, 0);
    finish_xfer(8'h96, 1, "R5 ext fall tx");
    chk(tog_cnt == tg, "R5 sclk_o still", tog_cnt, tg);
    cfg_sof = 0; cfg_msb = 1;
    set_idle();
    tg = tog_cnt;
    begin_xfer(8'h3E, 8'hB1, 1, 0);
    finish_xfer(8'h3E, 1, "R5 ext rise tx");
    chk(tog_cnt == tg, "R5 sclk_o still", tog_cnt, tg);

    // enable gating
    cfg_ext = 0; cfg_msb = 0; cfg_src = 2'b00; cfg_baud = 8'd0;
    set_idle();
    tx_en = 0;
    tg = tog_cnt;
    begin_xfer(8'h77, 8'h88, 1, 0);
    repeat (40) @(negedge clk);
    chk(tog_cnt == tg, "R1 no clock while disabled", tog_cnt, tg);
    chk(tx_ready == 0, "R1 byte held", int'(tx_ready), 0);
    tx_en = 1;
    finish_xfer(8'h77, 1, "R1 tx after enable");

    // clear-to-send blocking
    hs_off = 0; hs_rts = 0; cts_i = 1;
    tg = tog_cnt;
    begin_xfer(8'h4B, 8'hD2, 1, 0);
    repeat (40) @(negedge clk);
    chk(tog_cnt == tg, "R8 held by cts", tog_cnt, tg);
    chk(tx_ready == 0, "R8 byte held", int'(tx_ready), 0);
    chk(rts_o == 1, "R8 rts high", int'(rts_o), 1);
    cts_i = 0;
    finish_xfer(8'h4B, 1, "R8 tx after cts low");

    // ready-to-receive output
    hs_rts = 1; rx_ready = 0;
    @(negedge clk);
    chk(rts_o == 0, "R9 rts low idle", int'(rts_o), 0);
    begin_xfer(8'hE1, 8'h1E, 1, 0);
    repeat (3) @(negedge clk);
    chk(rts_o == 1, "R9 rts high busy", int'(rts_o), 1);
    finish_xfer(8'hE1, 1, "R9 tx");
    chk(rts_o == 1, "R9 rts high full", int'(rts_o), 1);
    rx_ready = 1;
    repeat (2) @(negedge clk);
    chk(rts_o == 0, "R9 rts low after read", int'(rts_o), 0);
    chk(rx_valid == 0, "R6 read clears", int'(rx_valid), 0);

    // overrun with error-only interrupt
    hs_off = 1; err_only = 1; rx_ready = 0;
    begin_xfer(8'h11, 8'h22, 0, 0);
    finish_xfer(8'h11, 0, "R10 no irq without error");
    begin_xfer(8'h33, 8'h44, 1, 1);
    finish_xfer(8'h33, 1, "R7 second tx");
    chk(ovr_err == 1, "R7 overrun set", int'(ovr_err), 1);
    chk(rx_data == 8'h44, "R7 data replaced", int'(rx_data), 8'h44);
    rx_ready = 1;
    repeat (2) @(negedge clk);
    chk(ovr_err == 0, "R7 read clears ovr", int'(ovr_err), 0);
    chk(q_data.size() == 0, "R6 all bytes read", q_data.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule